// File: doc/BRIEF.md
# Packed Lane Shifter

This block shifts a 64-bit packed operand by one shared count. The operand is split into four 16-bit lanes, two 32-bit lanes, or one 64-bit lane. Each lane is shifted on its own and no bit crosses from one lane into the next. The block supports two shifts. The first is a logical left shift, which moves zeros in from the bottom of each lane. The second is an arithmetic right shift on 32-bit lanes, which copies each lane's sign bit into the vacated top bits.

A small opcode decoder picks the operation. It reads an escape byte, an opcode byte and a register-select byte. The register-select byte has a 2-bit mode field in bits [7:6] and a 3-bit sub-operation field in bits [5:3]. The decoder decides whether the count comes from the 64-bit count operand or from the 8-bit immediate. The result is registered and appears one cycle after the valid strobe. The block accepts a new operation every cycle.

Counts are never taken modulo the lane width. The full count value decides the result. Any count that reaches the lane width clears every lane for a left shift and fills every lane with its sign bit for an arithmetic right shift.

Top module: `packed_lane_shifter`

## Requirements
- R1: While reset is asserted and after its release, `outValid`, `illegalOp` and `outData` are all 0 until the first operation completes.
- R2: Each cycle with `inValid` high produces `outValid` high in the next cycle. Each cycle with `inValid` low produces `outValid` low in the next cycle. Back-to-back operations complete on consecutive cycles.
- R3: When `outValid` is low, `outData` keeps its previous value.
- R4: Escape byte 0x0F with opcode byte 0xF1, 0xF2 or 0xF3 and mode field 11 performs a logical left shift on 16-, 32- or 64-bit lanes. The count comes from `regCount`. Zeros enter at the low end of each lane, and bits leaving a lane are lost.
- R5: Escape 0x0F with opcode 0xE2 and mode 11 performs an arithmetic right shift of each 32-bit lane by `regCount`. Each lane's bit 31 fills the vacated upper bits.
- R6: Escape 0x0F with opcode 0x71, 0x72 or 0x73, mode 11 and sub-operation 110 performs a left shift on 16-, 32- or 64-bit lanes by the unsigned `immCount`. Opcode 0x72 with sub-operation 100 performs the 32-bit arithmetic right shift by `immCount`. In every immediate form, `regCount` is ignored.
- R7: The whole count value is compared against the lane width, including counts such as 2^32+1 whose low bits are small. A count at or above the lane width gives all-zero lanes for left shifts and all-sign lanes for arithmetic right shifts.
- R8: The following encodings are illegal: an escape byte other than 0x0F, an unlisted opcode byte, a mode field other than 11, an immediate sub-operation other than 110 or 100, and sub-operation 100 with 0x71 or 0x73. An illegal encoding makes `illegalOp` and `outValid` high in the next cycle, with `outData` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| escByte | input | 8 | First opcode byte, 0x0F when legal |
| opByte | input | 8 | Second opcode byte, selects operation and lane size |
| modrm | input | 8 | Mode [7:6] and sub-operation [5:3] |
| srcData | input | 64 | Packed operand |
| regCount | input | 64 | Shift count for the register-count forms |
| immCount | input | 8 | Shift count for the immediate forms |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| outData | output | 64 | Shifted result |
| illegalOp | output | 1 | Decoded encoding was not a supported shift |

## Verification
Count selection and count saturation can act in the same cycle. An immediate-form operation arrives while `regCount` holds all ones, a value that would saturate every lane. The result is judged against a bit-by-bit model that uses only the immediate. A second case pairs a register-count operation whose count has small low bits with set upper bits; this must saturate rather than wrap. Operations are issued back to back with the strobe held high. Legal and illegal encodings alternate, so the zeroed illegal result and the following legal result are checked in adjacent cycles.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  localparam logic [7:0] ESC_BYTE   = 8'h0F;
  localparam logic [7:0] OP_SHL_W   = 8'hF1;
  localparam logic [7:0] OP_SHL_D   = 8'hF2;
  localparam logic [7:0] OP_SHL_Q   = 8'hF3;
  localparam logic [7:0] OP_SRA_D   = 8'hE2;
  localparam logic [7:0] OP_IMM_W   = 8'h71;
  localparam logic [7:0] OP_IMM_D   = 8'h72;
  localparam logic [7:0] OP_IMM_Q   = 8'h73;
  localparam logic [2:0] SUB_SHL    = 3'b110;
  localparam logic [2:0] SUB_SRA    = 3'b100;

  typedef enum logic [1:0] {
    LANE_NARROW = 2'd0,
    LANE_MID    = 2'd1,
    LANE_WIDE   = 2'd2
  } laneSize_e;

  typedef struct packed {
    logic      fire;
    logic      illegal;
    logic      arith;
    logic      useImm;
    laneSize_e lane;
  } shiftCtrl_t;
endpackage

// File: rtl/lsh_ctrl.sv
module lsh_ctrl
  import lsh_pkg::*;
(
  input  logic       inValid,
  input  logic [7:0] escByte,
  input  logic [7:0] opByte,
  input  logic [7:0] modrm,
  output shiftCtrl_t ctrl
);
  logic       legal;
  logic       regMode;
  logic [2:0] subOp;

  assign regMode = (escByte == ESC_BYTE) && (modrm[7:6] == 2'b11);
  assign subOp   = modrm[5:3];

  always_comb begin
    legal       = 1'b0;
    ctrl.arith  = 1'b0;
    ctrl.useImm = 1'b0;
    ctrl.lane   = LANE_NARROW;
    if (regMode) begin
      case (opByte)
        OP_SHL_W: begin legal = 1'b1; ctrl.lane = LANE_NARROW; end
        OP_SHL_D: begin legal = 1'b1; ctrl.lane = LANE_MID; end
        OP_SHL_Q: begin legal = 1'b1; ctrl.lane = LANE_WIDE; end
        OP_SRA_D: begin legal = 1'b1; ctrl.lane = LANE_MID; ctrl.arith = 1'b1; end
        OP_IMM_W: begin
          legal = (subOp == SUB_SHL); ctrl.useImm = 1'b1; ctrl.lane = LANE_NARROW;
        end
        OP_IMM_D: begin
          legal = (subOp == SUB_SHL) || (subOp == SUB_SRA);
          ctrl.useImm = 1'b1; ctrl.lane = LANE_MID;
          ctrl.arith = (subOp == SUB_SRA);
        end
        OP_IMM_Q: begin
          legal = (subOp == SUB_SHL); ctrl.useImm = 1'b1; ctrl.lane = LANE_WIDE;
        end
        default: legal = 1'b0;
      endcase
    end
    ctrl.fire    = inValid;
    ctrl.illegal = !legal;
  end
endmodule

// File: rtl/lsh_datapath.sv
module lsh_datapath
  import lsh_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftCtrl_t        ctrl,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] regCount,
  input  logic [IMM_W-1:0]  immCount,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              illegalOp
);
  localparam int NUM_SIZES = 3;

  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] sizeRes [NUM_SIZES];
  logic [DATA_W-1:0] selRes;

  assign count = ctrl.useImm ? DATA_W'(immCount) : regCount;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int LW    = DATA_W >> (NUM_SIZES - 1 - g);
    localparam int LANES = DATA_W / LW;
    localparam int AMT_W = $clog2(LW) + 1;
    logic [AMT_W-1:0] amt;
    assign amt = (count >= DATA_W'(LW)) ? AMT_W'(LW) : AMT_W'(count);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0] laneIn;
      logic [LW-1:0] leftOut;
      logic [LW-1:0] rightOut;
      assign laneIn   = srcData[l*LW +: LW];
      assign leftOut  = laneIn << amt;
      assign rightOut = LW'($signed(laneIn) >>> amt);
      assign sizeRes[g][l*LW +: LW] = ctrl.arith ? rightOut : leftOut;
    end
  end

  always_comb begin
    case (ctrl.lane)
      LANE_NARROW: selRes = sizeRes[0];
      LANE_MID:    selRes = sizeRes[1];
      default:     selRes = sizeRes[2];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= ctrl.fire;
      illegalOp <= ctrl.fire && ctrl.illegal;
      if (ctrl.fire) outData <= ctrl.illegal ? '0 : selRes;
    end
  end
endmodule

// File: rtl/packed_lane_shifter.sv
module packed_lane_shifter
  import lsh_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        escByte,
  input  logic [7:0]        opByte,
  input  logic [7:0]        modrm,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] regCount,
  input  logic [IMM_W-1:0]  immCount,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              illegalOp
);
  shiftCtrl_t ctrl;

  lsh_ctrl u_ctrl (
    .inValid (inValid),
    .escByte (escByte),
    .opByte  (opByte),
    .modrm   (modrm),
    .ctrl    (ctrl)
  );

  lsh_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .srcData   (srcData),
    .regCount  (regCount),
    .immCount  (immCount),
    .outValid  (outValid),
    .outData   (outData),
    .illegalOp (illegalOp)
  );
endmodule

// File: rtl/packed_lane_shifter_chk.sv
module packed_lane_shifter_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [7:0]        escByte,
  input logic [7:0]        opByte,
  input logic [7:0]        modrm,
  input logic [DATA_W-1:0] srcData,
  input logic [DATA_W-1:0] regCount,
  input logic [IMM_W-1:0]  immCount,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              illegalOp
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    if (!rstN) begin
      AST_RESET_IDLE: assert (!outValid && !illegalOp && outData == '0); // R1
    end
  end

  AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData)); // R3

  AST_WIDE_LEFT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && escByte == 8'h0F && opByte == 8'hF3 && modrm[7:6] == 2'b11
     && regCount >= DATA_W'(DATA_W)) |=> (outData == '0)); // R7

  AST_SRA_SIGN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && escByte == 8'h0F && opByte == 8'hE2 && modrm[7:6] == 2'b11
     && regCount >= DATA_W'(HALF))
    |=> (outData == {{HALF{$past(srcData[DATA_W-1])}}, {HALF{$past(srcData[HALF-1])}}})); // R5

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (outValid && outData == '0)); // R8

  AST_BAD_ESCAPE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && escByte != 8'h0F) |=> illegalOp); // R8
endmodule

bind packed_lane_shifter packed_lane_shifter_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/packed_lane_shifter_bench.sv
module packed_lane_shifter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  escByte = 8'h00;
  logic [7:0]  opByte = 8'h00;
  logic [7:0]  modrm = 8'h00;
  logic [63:0] srcData = '0;
  logic [63:0] regCount = '0;
  logic [7:0]  immCount = '0;
  logic        outValid;
  logic [63:0] outData;
  logic        illegalOp;

  int checkCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  packed_lane_shifter u_packed_lane_shifter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .escByte(escByte),
    .opByte(opByte), .modrm(modrm), .srcData(srcData), .regCount(regCount),
    .immCount(immCount), .outValid(outValid), .outData(outData),
    .illegalOp(illegalOp)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  function automatic logic [63:0] model(input logic [63:0] d, input logic [63:0] cnt,
                                        input int lw, input bit arith);
    logic [63:0] r = '0;
    for (int l = 0; l < 64 / lw; l++) begin
      for (int j = 0; j < lw; j++) begin
        if (arith) begin
          if (cnt < 64'(lw) && (j + int'(cnt)) < lw) r[l*lw + j] = d[l*lw + j + int'(cnt)];
          else r[l*lw + j] = d[l*lw + lw - 1];
        end else begin
          if (cnt < 64'(lw) && j >= int'(cnt)) r[l*lw + j] = d[l*lw + j - int'(cnt)];
          else r[l*lw + j] = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // Issue one operation at a falling edge; check it one edge later.
  task automatic issue(input string req, input logic [7:0] e, input logic [7:0] o,
                       input logic [7:0] m, input logic [63:0] d, input logic [63:0] rc,
                       input logic [7:0] ic, input logic [63:0] exp, input bit expIll);
    inValid = 1'b1; escByte = e; opByte = o; modrm = m;
    srcData = d; regCount = rc; immCount = ic;
    @(negedge clk);
    check({req, " R2 valid"}, 64'(outValid), 64'd1);
    check({req, " R8 flag"}, 64'(illegalOp), 64'(expIll));
    check(req, outData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checkCount++; failCount++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [63:0] pats [4];
    logic [7:0]  opc  [7];
    logic [7:0]  mrm  [7];
    int          lws  [7];
    bit          ars  [7];
    bit          imms [7];
    logic [63:0] heldData;
    pats[0] = 64'h8001_7FFF_F00D_1234;
    pats[1] = 64'h7FFF_8000_8123_4567;
    pats[2] = 64'hA5A5_5A5A_C3C3_3C3C;
    pats[3] = 64'hFFFF_FFFF_0000_0001;
    opc[0] = 8'hF1; mrm[0] = 8'hC8; lws[0] = 16; ars[0] = 0; imms[0] = 0;
    opc[1] = 8'hF2; mrm[1] = 8'hD1; lws[1] = 32; ars[1] = 0; imms[1] = 0;
    opc[2] = 8'hF3; mrm[2] = 8'hC2; lws[2] = 64; ars[2] = 0; imms[2] = 0;
    opc[3] = 8'hE2; mrm[3] = 8'hCB; lws[3] = 32; ars[3] = 1; imms[3] = 0;
    opc[4] = 8'h71; mrm[4] = 8'hF1; lws[4] = 16; ars[4] = 0; imms[4] = 1;
    opc[5] = 8'h72; mrm[5] = 8'hF2; lws[5] = 32; ars[5] = 0; imms[5] = 1;
    opc[6] = 8'h72; mrm[6] = 8'hE3; lws[6] = 32; ars[6] = 1; imms[6] = 1;

    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(outValid), 64'd0);
    check("R1 data in reset", outData, 64'd0);
    check("R1 flag in reset", 64'(illegalOp), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 64'(outValid), 64'd0);
    check("R1 data after reset", outData, 64'd0);

    // R4 R5 R6 R7 sweep, strobe held high back to back (R2)
    for (int k = 0; k < 7; k++) begin
      for (int p = 0; p < 4; p++) begin
        for (int c = 0; c < 75; c++) begin
          logic [63:0] cnt;
          cnt = (c < 71) ? 64'(c) : (c == 71) ? 64'd128 : (c == 72) ? 64'd255 :
                (c == 73) ? 64'h1_0000_0001 : 64'hFFFF_FFFF_FFFF_FFFF;
          if (imms[k]) begin
            if (c >= 73) continue;
            // R6 immediate count with a saturating register count present
            issue(ars[k] ? "R6 imm sra" : "R6 imm shl", 8'h0F, opc[k], mrm[k],
                  pats[p], 64'hFFFF_FFFF_FFFF_FFFF, cnt[7:0],
                  model(pats[p], cnt, lws[k], ars[k]), 1'b0);
          end else begin
            issue(c >= 73 ? "R7 full count" : (ars[k] ? "R5 reg sra" : "R4 reg shl"),
                  8'h0F, opc[k], mrm[k], pats[p], cnt, 8'h01,
                  model(pats[p], cnt, lws[k], ars[k]), 1'b0);
          end
        end
      end
    end
    issue("R6 imm qword", 8'h0F, 8'h73, 8'hF0, pats[0], 64'd0, 8'd4,
          model(pats[0], 64'd4, 64, 1'b0), 1'b0);

    // R8 illegal encodings, interleaved with legal ones
    issue("R8 bad escape", 8'h0E, 8'hF1, 8'hC0, pats[0], 64'd1, 8'd0, 64'd0, 1'b1);
    issue("R4 after illegal", 8'h0F, 8'hF1, 8'hC0, pats[0], 64'd1, 8'd0,
          model(pats[0], 64'd1, 16, 1'b0), 1'b0);
    issue("R8 unknown opcode", 8'h0F, 8'h74, 8'hC0, pats[1], 64'd1, 8'd0, 64'd0, 1'b1);
    issue("R8 memory mode", 8'h0F, 8'hF2, 8'h80, pats[1], 64'd1, 8'd0, 64'd0, 1'b1);
    issue("R8 imm mode", 8'h0F, 8'h72, 8'h71, pats[1], 64'd0, 8'd1, 64'd0, 1'b1);
    issue("R8 imm sub 010", 8'h0F, 8'h71, 8'hD0, pats[2], 64'd0, 8'd1, 64'd0, 1'b1);
    issue("R8 sra on word", 8'h0F, 8'h71, 8'hE0, pats[2], 64'd0, 8'd1, 64'd0, 1'b1);
    issue("R8 sra on qword", 8'h0F, 8'h73, 8'hE0, pats[2], 64'd0, 8'd1, 64'd0, 1'b1);
    issue("R5 after illegal", 8'h0F, 8'hE2, 8'hC0, pats[1], 64'd4, 8'd0,
          model(pats[1], 64'd4, 32, 1'b1), 1'b0);

    // R3 hold while idle
    heldData = model(pats[1], 64'd4, 32, 1'b1);
    inValid = 1'b0; srcData = pats[3]; regCount = 64'd0; opByte = 8'h74;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 idle valid low", 64'(outValid), 64'd0);
      check("R3 data held", outData, heldData);
    end
    finishRun();
  end
endmodule